// File: doc/BRIEF.md
# Transceiver Management and Link-Mode Bring-Up Sequencer

This block brings an Ethernet controller's link mode up after reset without software. It holds a serial management master that drives the management clock and the bidirectional data line toward an external transceiver at fixed address 1. A bring-up sequencer uses that master to decide how the controller should run, and publishes the result as a 32-bit operating-mode word.

After reset the mode word carries only the store-and-forward bit (bit 21). A device-variant input selects one of two paths. The simple variant forces the transceiver into basic 10 Mb/s operation and ends. The full variant polls the transceiver's status register until both link bits are set, then reads the duplex status. If the link never comes up within a cycle-count timeout, the sequencer selects an alternate home-networking port instead. It then identifies and programs the transceiver found there.

The `done` output rises once the final mode word is in place and every management frame has finished. It stays high until the next reset.

Top module: `phy_mgmt_bringup`

## Requirements
- R1: While reset is high and right after it, `mode_word` is 0x00200000, `done` is 0, `mdc` is low and `mdio_oe` is 0. Bits other than 21, 18 and 9 are never set.
- R2: Every frame starts with at least 34 clocks of data 1, then start bits 0,1. Next come the opcode (read 1,0; write 0,1), PHY address 1, then the 5-bit register address, all MSB first.
- R3: A read frame releases the data line (`mdio_oe` = 0) for one turnaround clock and 16 data clocks. It captures `mdio_in` on each rising `mdc` edge, MSB first.
- R4: A write frame drives turnaround bits 1,0, then 16 data bits MSB first. `mdio_out` does not change while `mdc` is high.
- R5: With `simple_variant` = 1, the only frame is a write of 0x0000 to register 0, and `mode_word` stays 0x00200000.
- R6: With `simple_variant` = 0, register 1 is read repeatedly until a value has bits 2 and 5 both set (one bit alone is not link). Register 17 is then read, and bit 9 of `mode_word` is set when bit 15 or bit 13 of that value is 1.
- R7: If register 1 shows no link once TIMEOUT_CYC cycles of polling have elapsed, `mode_word` bit 18 is set and register 3 is read. When (reg3 & 0xFFF0) != 0xB900, no further frame follows.
- R8: When (reg3 & 0xFFF0) == 0xB900 and register 31 reads 0x4404, the sequencer writes register 16. The value is 0x0005 if reg3 == 0xB901 and 0x1005 otherwise. It then reads register 24 and writes register 25 with ((reg24 + 3) & 0xFF) | 0xF000.
- R9: When (reg3 & 0xFFF0) == 0xB900 and register 31 differs from 0x4404, the sequencer writes 0x0005 to register 16. It then reads register 25 and writes back (reg25 & 0xFF00) + 2.
- R10: `done` rises only after the last frame ends. It then stays high with `mode_word` stable, `mdc` low and the data line released.
- R11: Each `mdc` high phase and each low phase within a frame lasts MDC_HALF_CYC system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts a new bring-up |
| simple_variant | input | 1 | 1 selects the fixed 10 Mb/s device variant |
| mdio_in | input | 1 | Management data line as seen from the transceiver |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data driven toward the transceiver |
| mdio_oe | output | 1 | Output enable for `mdio_out` |
| mode_word | output | 32 | Operating-mode word (21 store-and-forward, 18 alternate port, 9 full duplex) |
| done | output | 1 | Bring-up complete |

## Verification
The assertions assume that reset is held for at least one clock before the sequence runs. They also assume that `simple_variant` stays constant from reset release until `done`. The bench only changes that input while reset is high. The transceiver model drives `mdio_in` on falling `mdc` edges during read data, so the value is settled a full half period before each capture edge. The model returns 1 whenever the line is released. Link status is scripted per run: up at once, up after a set number of polls, or never up. This lets the bench reach the timeout and both alternate-port transceiver types.

// File: rtl/mgmt_seq_pkg.sv
package mgmt_seq_pkg;

  localparam logic [4:0]  XCVR_ADDR     = 5'd1;
  localparam logic [31:0] MODE_INIT     = 32'h0020_0000;
  localparam int unsigned MODE_FDX_BIT  = 9;
  localparam int unsigned MODE_ALT_BIT  = 18;

  // one management transaction request
  typedef struct packed {
    logic        wr;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mgmt_req_t;

  typedef enum logic [3:0] {
    ST_BEGIN,
    ST_FORCE10,
    ST_POLL,
    ST_DUPLEX,
    ST_ALT_ID,
    ST_ALT_KIND,
    ST_A_CFG,
    ST_A_RD24,
    ST_A_W25,
    ST_B_CFG,
    ST_B_RD25,
    ST_B_W25,
    ST_FINISH,
    ST_IDLE
  } seq_state_t;

endpackage

// File: rtl/mdc_phase_gen.sv
module mdc_phase_gen #(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned PERIOD = 2 * HALF_CYC;
  localparam int unsigned CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == CW'(PERIOD - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign rise_tick = run && (cnt == CW'(HALF_CYC - 1));
  assign fall_tick = run && (cnt == CW'(PERIOD - 1));

endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
  import mgmt_seq_pkg::*;
#(
  parameter int unsigned HALF_CYC = 4,
  parameter int unsigned PRE_LEN  = 34
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  mgmt_req_t   req,
  output logic        busy,
  output logic        done_p,
  output logic [15:0] rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int unsigned RD_LEN    = PRE_LEN + 31;
  localparam int unsigned WR_LEN    = PRE_LEN + 32;
  localparam int unsigned CAP_FIRST = PRE_LEN + 15;
  localparam int unsigned IW        = $clog2(WR_LEN + 1);

  mgmt_req_t      cur;
  logic [IW-1:0]  idx;
  logic [IW-1:0]  nidx;
  logic [IW-1:0]  off;
  logic [31:0]    wr_tail;
  logic [13:0]    rd_head;
  logic           last;
  logic           nbit;
  logic           noe;
  logic           rise_tick;
  logic           fall_tick;

  mdc_phase_gen #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick)
  );

  // value and enable of the bit that follows the current one
  always_comb begin
    wr_tail = {2'b01, 2'b01, XCVR_ADDR, cur.regad, 2'b10, cur.wdata};
    rd_head = {2'b01, 2'b10, XCVR_ADDR, cur.regad};
    last    = cur.wr ? (idx == IW'(WR_LEN - 1)) : (idx == IW'(RD_LEN - 1));
    nidx    = idx + 1'b1;
    off     = nidx - IW'(PRE_LEN);
    nbit    = 1'b1;
    noe     = 1'b1;
    if (nidx >= IW'(PRE_LEN)) begin
      if (cur.wr) begin
        nbit = wr_tail[5'd31 - off[4:0]];
      end else if (off < IW'(14)) begin
        nbit = rd_head[4'd13 - off[3:0]];
      end else begin
        nbit = 1'b0;
        noe  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= '0;
      idx      <= '0;
      busy     <= 1'b0;
      done_p   <= 1'b0;
      rdata    <= '0;
      mdc      <= 1'b0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else begin
      done_p <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          cur      <= req;
          idx      <= '0;
          mdio_out <= 1'b1;
          mdio_oe  <= 1'b1;
        end
      end else begin
        if (rise_tick) begin
          mdc <= 1'b1;
          if (!cur.wr && idx >= IW'(CAP_FIRST)) begin
            rdata <= {rdata[14:0], mdio_in};
          end
        end
        if (fall_tick) begin
          mdc <= 1'b0;
          if (last) begin
            busy     <= 1'b0;
            done_p   <= 1'b1;
            mdio_out <= 1'b0;
            mdio_oe  <= 1'b0;
          end else begin
            idx      <= nidx;
            mdio_out <= nbit;
            mdio_oe  <= noe;
          end
        end
      end
    end
  end

endmodule

// File: rtl/media_sense_seq.sv
module media_sense_seq
  import mgmt_seq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 250_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        simple_variant,
  output logic        m_start,
  output mgmt_req_t   m_req,
  input  logic        m_busy,
  input  logic        m_done,
  input  logic [15:0] m_rdata,
  output logic [31:0] mode_word,
  output logic        done
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);

  seq_state_t  state;
  logic        waiting;
  logic        is_op;
  logic [15:0] id_word;
  logic [15:0] scratch;
  logic [TW-1:0] poll_cnt;
  logic        expired;
  logic        link_ok;
  logic        fdx;

  assign expired = (poll_cnt >= TW'(TIMEOUT_CYC));
  assign link_ok = (m_rdata & 16'h0024) == 16'h0024;
  assign fdx     = |(m_rdata & 16'hA000);

  // transaction issued in each state
  always_comb begin
    is_op = 1'b1;
    m_req = '0;
    case (state)
      ST_FORCE10:  begin m_req.wr = 1'b1; m_req.regad = 5'd0; m_req.wdata = 16'h0000; end
      ST_POLL:     m_req.regad = 5'd1;
      ST_DUPLEX:   m_req.regad = 5'd17;
      ST_ALT_ID:   m_req.regad = 5'd3;
      ST_ALT_KIND: m_req.regad = 5'd31;
      ST_A_CFG: begin
        m_req.wr    = 1'b1;
        m_req.regad = 5'd16;
        m_req.wdata = (id_word == 16'hB901) ? 16'h0005 : 16'h1005;
      end
      ST_A_RD24:   m_req.regad = 5'd24;
      ST_A_W25: begin
        m_req.wr    = 1'b1;
        m_req.regad = 5'd25;
        m_req.wdata = {8'hF0, scratch[7:0] + 8'd3};
      end
      ST_B_CFG: begin m_req.wr = 1'b1; m_req.regad = 5'd16; m_req.wdata = 16'h0005; end
      ST_B_RD25:   m_req.regad = 5'd25;
      ST_B_W25: begin
        m_req.wr    = 1'b1;
        m_req.regad = 5'd25;
        m_req.wdata = {scratch[15:8], 8'h02};
      end
      default:     is_op = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_BEGIN;
      waiting   <= 1'b0;
      m_start   <= 1'b0;
      id_word   <= '0;
      scratch   <= '0;
      poll_cnt  <= '0;
      mode_word <= MODE_INIT;
      done      <= 1'b0;
    end else begin
      m_start <= 1'b0;
      if (state == ST_POLL && !expired) begin
        poll_cnt <= poll_cnt + 1'b1;
      end
      if (is_op && !waiting && !m_busy) begin
        m_start <= 1'b1;
        waiting <= 1'b1;
      end else if (waiting && m_done) begin
        waiting <= 1'b0;
        case (state)
          ST_FORCE10: state <= ST_FINISH;
          ST_POLL: begin
            if (link_ok) begin
              state <= ST_DUPLEX;
            end else if (expired) begin
              mode_word[MODE_ALT_BIT] <= 1'b1;
              state <= ST_ALT_ID;
            end
          end
          ST_DUPLEX: begin
            if (fdx) mode_word[MODE_FDX_BIT] <= 1'b1;
            state <= ST_FINISH;
          end
          ST_ALT_ID: begin
            id_word <= m_rdata;
            state   <= ((m_rdata & 16'hFFF0) == 16'hB900) ? ST_ALT_KIND : ST_FINISH;
          end
          ST_ALT_KIND: state <= (m_rdata == 16'h4404) ? ST_A_CFG : ST_B_CFG;
          ST_A_CFG:    state <= ST_A_RD24;
          ST_A_RD24: begin
            scratch <= m_rdata;
            state   <= ST_A_W25;
          end
          ST_B_CFG:    state <= ST_B_RD25;
          ST_B_RD25: begin
            scratch <= m_rdata;
            state   <= ST_B_W25;
          end
          default:     state <= ST_FINISH;
        endcase
      end else if (!is_op) begin
        case (state)
          ST_BEGIN:  state <= simple_variant ? ST_FORCE10 : ST_POLL;
          ST_FINISH: begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
          default:   state <= state;
        endcase
      end
    end
  end

endmodule

// File: rtl/phy_mgmt_bringup.sv
module phy_mgmt_bringup
  import mgmt_seq_pkg::*;
#(
  parameter int unsigned MDC_HALF_CYC = 4,
  parameter int unsigned PRE_LEN      = 34,
  parameter int unsigned TIMEOUT_CYC  = 250_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        simple_variant,
  input  logic        mdio_in,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  output logic [31:0] mode_word,
  output logic        done
);
  logic        m_start;
  logic        m_busy;
  logic        m_done;
  logic [15:0] m_rdata;
  mgmt_req_t   m_req;

  media_sense_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .simple_variant(simple_variant),
    .m_start       (m_start),
    .m_req         (m_req),
    .m_busy        (m_busy),
    .m_done        (m_done),
    .m_rdata       (m_rdata),
    .mode_word     (mode_word),
    .done          (done)
  );

  mgmt_frame_master #(.HALF_CYC(MDC_HALF_CYC), .PRE_LEN(PRE_LEN)) u_mgmt (
    .clk     (clk),
    .rst     (rst),
    .start   (m_start),
    .req     (m_req),
    .busy    (m_busy),
    .done_p  (m_done),
    .rdata   (m_rdata),
    .mdc     (mdc),
    .mdio_out(mdio_out),
    .mdio_oe (mdio_oe),
    .mdio_in (mdio_in)
  );

endmodule

// File: rtl/phy_mgmt_bringup_chk.sv
module phy_mgmt_bringup_chk (
  input logic        clk,
  input logic        rst,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic [31:0] mode_word,
  input logic        done,
  input logic        m_busy,
  input logic        m_start
);

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode_word[21] && ((mode_word & ~32'h0024_0200) == 32'h0)); // R1

  AST_FDX_ALT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mode_word[9] && mode_word[18])); // R7

  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_out)); // R4

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    m_start |-> !m_busy); // R2

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R10

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!m_busy && !mdc && !mdio_oe)); // R10

  AST_DONE_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> $stable(mode_word)); // R10

endmodule

bind phy_mgmt_bringup phy_mgmt_bringup_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mdc      (mdc),
  .mdio_out (mdio_out),
  .mdio_oe  (mdio_oe),
  .mode_word(mode_word),
  .done     (done),
  .m_busy   (m_busy),
  .m_start  (m_start)
);

// File: tb/phy_mgmt_bringup_test.sv
module phy_mgmt_bringup_test;
  localparam int HALF = 2;
  localparam int TMO  = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        simple_variant = 1'b0;
  logic        mdio_in = 1'b1;
  logic        mdc, mdio_out, mdio_oe, done;
  logic [31:0] mode_word;

  always #2 clk = ~clk;

  phy_mgmt_bringup #(.MDC_HALF_CYC(HALF), .PRE_LEN(34), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst(rst), .simple_variant(simple_variant), .mdio_in(mdio_in),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .mode_word(mode_word), .done(done)
  );

  int checks = 0;
  int failures = 0;

  // transceiver register image for the current run
  int          link_after;
  int          r1_reads;
  int          poll_reads;
  logic [15:0] r1_dn, r1_up, v17, v3, v31, v24, v25;
  bit          oe_bad, ta_bad, mdc_bad;
  int          hi_cnt = 0;

  logic [21:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic push_exp(bit wr, logic [4:0] r, logic [15:0] d, string tag);
    exp_q.push_back({wr, r, d});
    tag_q.push_back(tag);
  endtask

  function automatic logic [15:0] reg_value(logic [4:0] r);
    case (r)
      5'd1:    return (r1_reads < link_after) ? r1_dn : r1_up;
      5'd3:    return v3;
      5'd17:   return v17;
      5'd24:   return v24;
      5'd25:   return v25;
      5'd31:   return v31;
      default: return 16'h0000;
    endcase
  endfunction

  // scoreboard compare of one decoded frame
  task automatic score(bit wr, logic [4:0] r, logic [15:0] d);
    logic [21:0] e;
    string       t;
    chk(!done, "R10", "done high during a frame", {31'd0, done}, 32'd0);
    if (!wr && r == 5'd1) begin
      poll_reads++;
    end else if (exp_q.size() == 0) begin
      chk(1'b0, "R2", "unexpected frame", {10'd0, wr, r, d}, 32'd0);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (wr) chk({wr, r, d} == e, t, "write frame", {10'd0, wr, r, d}, {10'd0, e});
      else    chk({wr, r} == e[21:16], t, "read frame", {26'd0, wr, r}, {26'd0, e[21:16]});
    end
  endtask

  // monitor / transceiver model
  initial begin
    int          ones;
    logic        s1, o1, o0, t1, t0;
    logic [4:0]  pa, ra;
    logic [15:0] d, val;
    ones = 0;
    forever begin
      @(posedge mdc);
      if (mdio_oe && mdio_out) begin
        ones++;
      end else if (mdio_oe && !mdio_out && ones >= 32) begin
        chk(ones >= 34, "R2", "preamble length", ones, 34);
        ones = 0;
        @(posedge mdc); s1 = mdio_out;
        chk(s1 == 1'b1, "R2", "second start bit", {31'd0, s1}, 32'd1);
        @(posedge mdc); o1 = mdio_out;
        @(posedge mdc); o0 = mdio_out;
        for (int k = 4; k >= 0; k--) begin @(posedge mdc); pa[k] = mdio_out; end
        for (int k = 4; k >= 0; k--) begin @(posedge mdc); ra[k] = mdio_out; end
        chk(pa == 5'd1, "R2", "phy address", {27'd0, pa}, 32'd1);
        if ({o1, o0} == 2'b10) begin
          val = reg_value(ra);
          if (ra == 5'd1) r1_reads++;
          @(negedge mdc);
          @(negedge mdc);
          for (int k = 15; k >= 0; k--) begin
            mdio_in = val[k];
            @(posedge mdc);
            if (mdio_oe) oe_bad = 1'b1;
            @(negedge mdc);
          end
          mdio_in = 1'b1;
          score(1'b0, ra, 16'h0);
        end else begin
          chk({o1, o0} == 2'b01, "R2", "opcode", {30'd0, o1, o0}, 32'd1);
          @(posedge mdc); t1 = mdio_out;
          @(posedge mdc); t0 = mdio_out;
          if ({t1, t0} != 2'b10) ta_bad = 1'b1;
          for (int k = 15; k >= 0; k--) begin @(posedge mdc); d[k] = mdio_out; end
          score(1'b1, ra, d);
        end
      end else begin
        ones = 0;
      end
    end
  end

  // management clock high-phase length, R11
  always @(negedge clk) begin
    if (mdc) hi_cnt = hi_cnt + 1;
    else if (hi_cnt != 0) begin
      if (hi_cnt != HALF) mdc_bad = 1'b1;
      hi_cnt = 0;
    end
  end

  task automatic run_case(bit simple, int la, logic [15:0] dn, logic [15:0] up,
                          logic [15:0] a17, logic [15:0] a3, logic [15:0] a31,
                          logic [15:0] a24, logic [15:0] a25, logic [31:0] exp_mode,
                          int pmin, int pmax, string tag);
    int cyc;
    bit quiet_bad;
    link_after = la; r1_dn = dn; r1_up = up;
    v17 = a17; v3 = a3; v31 = a31; v24 = a24; v25 = a25;
    r1_reads = 0; poll_reads = 0;
    oe_bad = 0; ta_bad = 0; mdc_bad = 0;
    rst = 1'b1;
    simple_variant = simple;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mode_word == 32'h0020_0000, "R1", "reset mode word", mode_word, 32'h0020_0000);
    chk(!done && !mdc && !mdio_oe, "R1", "reset outputs", {29'd0, done, mdc, mdio_oe}, 32'd0);
    rst = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(done, "R10", "done raised", {31'd0, done}, 32'd1);
    chk(mode_word == exp_mode, tag, "final mode word", mode_word, exp_mode);
    chk(exp_q.size() == 0, tag, "frames still expected", exp_q.size(), 0);
    chk(poll_reads >= pmin && poll_reads <= pmax, "R6", "link poll count", poll_reads, pmin);
    quiet_bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (mdc || mdio_oe || !done) quiet_bad = 1'b1;
    end
    chk(!quiet_bad, "R10", "idle after done", {31'd0, quiet_bad}, 32'd0);
    chk(!oe_bad, "R3", "line released in read data", {31'd0, oe_bad}, 32'd0);
    chk(!ta_bad, "R4", "write turnaround 1,0", {31'd0, ta_bad}, 32'd0);
    chk(!mdc_bad, "R11", "mdc high phase length", {31'd0, mdc_bad}, 32'd0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    // R5 simple variant
    push_exp(1'b1, 5'd0, 16'h0000, "R5");
    run_case(1'b1, 0, 16'h0, 16'h0024, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0,
             32'h0020_0000, 0, 0, "R5");
    // R6 link at once, full duplex from bit 15
    push_exp(1'b0, 5'd17, 16'h0, "R6");
    run_case(1'b0, 0, 16'h0, 16'h002D, 16'h8000, 16'h0, 16'h0, 16'h0, 16'h0,
             32'h0020_0200, 1, 1, "R6");
    // R6 link, bit 14 only is not duplex
    push_exp(1'b0, 5'd17, 16'h0, "R6");
    run_case(1'b0, 0, 16'h0, 16'h0024, 16'h4000, 16'h0, 16'h0, 16'h0, 16'h0,
             32'h0020_0000, 1, 1, "R6");
    // R6 link after two failed polls (bit 2 alone), duplex from bit 13
    push_exp(1'b0, 5'd17, 16'h0, "R6");
    run_case(1'b0, 2, 16'h0004, 16'h0024, 16'h2000, 16'h0, 16'h0, 16'h0, 16'h0,
             32'h0020_0200, 3, 3, "R6");
    // R7 timeout with bit 5 alone, unknown transceiver id
    push_exp(1'b0, 5'd3, 16'h0, "R7");
    run_case(1'b0, 100000, 16'h0020, 16'h0024, 16'h0, 16'h1234, 16'h0, 16'h0, 16'h0,
             32'h0024_0000, 2, 100, "R7");
    // R8 first type, id 0xB901
    push_exp(1'b0, 5'd3, 16'h0, "R7");
    push_exp(1'b0, 5'd31, 16'h0, "R8");
    push_exp(1'b1, 5'd16, 16'h0005, "R8");
    push_exp(1'b0, 5'd24, 16'h0, "R8");
    push_exp(1'b1, 5'd25, 16'hF001, "R8");
    run_case(1'b0, 100000, 16'h0000, 16'h0024, 16'h0, 16'hB901, 16'h4404, 16'h00FE, 16'h0,
             32'h0024_0000, 2, 100, "R8");
    // R8 first type, other id
    push_exp(1'b0, 5'd3, 16'h0, "R7");
    push_exp(1'b0, 5'd31, 16'h0, "R8");
    push_exp(1'b1, 5'd16, 16'h1005, "R8");
    push_exp(1'b0, 5'd24, 16'h0, "R8");
    push_exp(1'b1, 5'd25, 16'hF013, "R8");
    run_case(1'b0, 100000, 16'h0000, 16'h0024, 16'h0, 16'hB90C, 16'h4404, 16'h1210, 16'h0,
             32'h0024_0000, 2, 100, "R8");
    // R9 second type
    push_exp(1'b0, 5'd3, 16'h0, "R7");
    push_exp(1'b0, 5'd31, 16'h0, "R9");
    push_exp(1'b1, 5'd16, 16'h0005, "R9");
    push_exp(1'b0, 5'd25, 16'h0, "R9");
    push_exp(1'b1, 5'd25, 16'hAB02, "R9");
    run_case(1'b0, 100000, 16'h0000, 16'h0024, 16'h0, 16'hB900, 16'h4405, 16'h0, 16'hAB77,
             32'h0024_0000, 2, 100, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule